// File: doc/BRIEF.md
# Floating-Point Exception and NaN Status Controller

This block sits beside a floating-point datapath and keeps the exception state of the unit. For every completed operation it inspects both source operands, detects signalling NaNs, quiet NaNs and denormal encodings, and merges what it finds with the exception flags that the arithmetic datapath reports. The merged flags are collected into six sticky status bits. They stay set until software issues a clear command.

A per-exception mask vector decides which sticky bits count toward the error summary. The busy indication follows the error summary. An unmasked exception does not interrupt at once. The request is raised only when the next qualifying instruction is about to begin, and it stays raised until the handler acknowledges it.

For operations that involve a NaN, the block also supplies the quiet NaN to write as the result. A signalling operand is converted to its quiet form on the way out.

Top module: `fpx_status_ctrl`

## Requirements
- R1: An operand whose exponent field is all ones and whose fraction is nonzero is a NaN. If its top fraction bit is 0 it is signalling. A signalling NaN on either operand of a valid operation sets the Invalid sticky bit (bit 0) one cycle later.
- R2: A quiet NaN operand (top fraction bit 1) does not set the Invalid bit by itself.
- R3: An operand with an all-zero exponent and a nonzero fraction is denormal. Such an operand in a valid operation sets the Denormal sticky bit (bit 1).
- R4: The flags input from the datapath uses this bit order: 0 invalid, 1 denormal, 2 zero-divide, 3 overflow, 4 underflow, 5 precision. Its flags are ORed into the sticky bits at the same positions, and the result is visible on the cycle after the valid operation.
- R5: Sticky bits accumulate across operations and never fall without a clear. Flags and operands presented while op_valid is low have no effect.
- R6: A clear command zeroes all sticky bits on the next cycle. It takes priority over flags from an operation in the same cycle.
- R7: err_summary is the OR over all six bits of (sticky AND NOT mask), where mask bit 1 means masked. It follows the mask input in the same cycle.
- R8: busy always equals err_summary.
- R9: irq rises only on the cycle after insn_start is seen while err_summary is high. Without insn_start, or with err_summary low, it stays low.
- R10: Once raised, irq stays high, even after the flags are cleared, until irq_ack. irq_ack drops it on the next cycle and wins over a same-cycle insn_start.
- R11: nan_valid is high when op_valid is high and either operand is a NaN. nan_result is that operand with its top fraction bit forced to 1, and operand A is chosen when both are NaN.
- R12: After reset, the sticky bits, err_summary, busy and irq are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation completes this cycle |
| op_a | input | 32 | First source operand |
| op_b | input | 32 | Second source operand |
| dp_flags | input | 6 | Exception flags from the datapath |
| exc_mask | input | 6 | Per-exception mask, 1 = masked |
| clear_flags | input | 1 | Clear all sticky bits |
| insn_start | input | 1 | Next qualifying instruction is about to start |
| irq_ack | input | 1 | Handler acknowledges the request |
| sticky | output | 6 | Sticky exception bits |
| err_summary | output | 1 | Any unmasked sticky bit set |
| busy | output | 1 | Mirror of err_summary |
| irq | output | 1 | Deferred exception interrupt request |
| nan_result | output | 32 | Quiet NaN to propagate |
| nan_valid | output | 1 | nan_result applies to this operation |

## Verification
The vector table covers several operand pairs:
- normal values, which must leave the status untouched;
- a signalling NaN in either position, with positive and negative signs;
- a quiet NaN, which must not raise Invalid;
- denormals of both signs;
- infinity with zero, which looks close to a NaN or a denormal but is neither.

Together these separate the quiet and signalling cases, the denormal test and the operand priority for the NaN result. Datapath flag patterns are mixed with different masks, so that a wrong bit position or a masked bit that leaks into the summary shows up as a wrong err_summary.

The directed tests then check the rest of the block's timing:
- the interrupt request waits for the instruction boundary and ignores boundaries when no unmasked exception is pending;
- the request survives a flag clear;
- acknowledge beats a same-cycle boundary;
- clear beats a same-cycle operation;
- flags presented without op_valid are dropped.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    localparam int NUM_EXC = 6;

    // Bit positions inside the exception vector; the mask and the datapath
    // flags share this order.
    localparam int EX_INV = 0;
    localparam int EX_DEN = 1;
    localparam int EX_ZDV = 2;
    localparam int EX_OVF = 3;
    localparam int EX_UNF = 4;
    localparam int EX_PRE = 5;

    typedef logic [NUM_EXC-1:0] exc_vec_t;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
        logic is_denorm;
    } op_class_t;

endpackage

// File: rtl/fpx_classify.sv
module fpx_classify
    import fpx_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] word_i,
    output op_class_t             cls_o
);
    localparam int WORD_W = 1 + EXP_W + FRAC_W;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              frac_nz;

    assign exp_f   = word_i[WORD_W-2 -: EXP_W];
    assign frac_f  = word_i[FRAC_W-1:0];
    assign frac_nz = |frac_f;

    always_comb begin
        cls_o.is_nan    = (&exp_f) & frac_nz;
        cls_o.is_snan   = (&exp_f) & frac_nz & ~frac_f[FRAC_W-1];
        cls_o.is_denorm = (~|exp_f) & frac_nz;
    end
endmodule

// File: rtl/fpx_nan_select.sv
module fpx_nan_select
    import fpx_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                  valid_i,
    input  logic [EXP_W+FRAC_W:0] a_i,
    input  logic [EXP_W+FRAC_W:0] b_i,
    input  op_class_t             cls_a_i,
    input  op_class_t             cls_b_i,
    output logic [EXP_W+FRAC_W:0] nan_o,
    output logic                  nan_valid_o
);
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam logic [WORD_W-1:0] QUIET_BIT =
        {{(EXP_W+1){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [WORD_W-1:0] DEFAULT_QNAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    always_comb begin
        if (cls_a_i.is_nan)      nan_o = a_i | QUIET_BIT;
        else if (cls_b_i.is_nan) nan_o = b_i | QUIET_BIT;
        else                     nan_o = DEFAULT_QNAN;
        nan_valid_o = valid_i & (cls_a_i.is_nan | cls_b_i.is_nan);
    end
endmodule

// File: rtl/fpx_sticky_bank.sv
module fpx_sticky_bank
    import fpx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     update_i,
    input  logic     clear_i,
    input  exc_vec_t new_i,
    output exc_vec_t sticky_o
);
    exc_vec_t sticky_q;

    always_ff @(posedge clk) begin
        if (rst)           sticky_q <= '0;
        else if (clear_i)  sticky_q <= '0;
        else if (update_i) sticky_q <= sticky_q | new_i;
    end

    assign sticky_o = sticky_q;

    // R5
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !clear_i |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));

    // R6
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (sticky_q == '0));
endmodule

// File: rtl/fpx_irq_ctrl.sv
module fpx_irq_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic pending_i,
    input  logic insn_start_i,
    input  logic ack_i,
    output logic irq_o
);
    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst)                            irq_q <= 1'b0;
        else if (ack_i)                     irq_q <= 1'b0;
        else if (insn_start_i && pending_i) irq_q <= 1'b1;
    end

    assign irq_o = irq_q;

    // R9
    irq_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> $past(insn_start_i && pending_i));

    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !ack_i) |=> irq_q);

    // R10
    irq_ack_chk: assert property (@(posedge clk) disable iff (rst)
        ack_i |=> !irq_q);
endmodule

// File: rtl/fpx_status_ctrl.sv
module fpx_status_ctrl
    import fpx_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic [NUM_EXC-1:0] dp_flags,
    input  logic [NUM_EXC-1:0] exc_mask,
    input  logic              clear_flags,
    input  logic              insn_start,
    input  logic              irq_ack,
    output logic [NUM_EXC-1:0] sticky,
    output logic              err_summary,
    output logic              busy,
    output logic              irq,
    output logic [WORD_W-1:0] nan_result,
    output logic              nan_valid
);
    localparam int NUM_OPS = 2;

    logic [WORD_W-1:0] ops [NUM_OPS];
    op_class_t         cls [NUM_OPS];
    exc_vec_t          detected;
    exc_vec_t          sticky_w;
    logic              any_snan;
    logic              any_den;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_cls
        fpx_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) cls_i (
            .word_i (ops[g]),
            .cls_o  (cls[g])
        );
    end

    always_comb begin
        any_snan = 1'b0;
        any_den  = 1'b0;
        for (int i = 0; i < NUM_OPS; i++) begin
            any_snan = any_snan | cls[i].is_snan;
            any_den  = any_den  | cls[i].is_denorm;
        end
        detected         = dp_flags;
        detected[EX_INV] = dp_flags[EX_INV] | any_snan;
        detected[EX_DEN] = dp_flags[EX_DEN] | any_den;
    end

    fpx_sticky_bank bank_i (
        .clk      (clk),
        .rst      (rst),
        .update_i (op_valid),
        .clear_i  (clear_flags),
        .new_i    (detected),
        .sticky_o (sticky_w)
    );

    assign sticky      = sticky_w;
    assign err_summary = |(sticky_w & ~exc_mask);
    assign busy        = err_summary;

    fpx_irq_ctrl irq_i (
        .clk          (clk),
        .rst          (rst),
        .pending_i    (err_summary),
        .insn_start_i (insn_start),
        .ack_i        (irq_ack),
        .irq_o        (irq)
    );

    fpx_nan_select #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) nan_i (
        .valid_i     (op_valid),
        .a_i         (op_a),
        .b_i         (op_b),
        .cls_a_i     (cls[0]),
        .cls_b_i     (cls[1]),
        .nan_o       (nan_result),
        .nan_valid_o (nan_valid)
    );

    // R1
    snan_invalid_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !clear_flags && (cls[0].is_snan || cls[1].is_snan))
        |=> sticky_w[EX_INV]);

    // R3
    denorm_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !clear_flags && (cls[0].is_denorm || cls[1].is_denorm))
        |=> sticky_w[EX_DEN]);
endmodule

// File: tb/fpx_status_ctrl_tb_top.sv
module fpx_status_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 9;

    // Vector table: operands, datapath flags, mask, expected sticky bits
    // (starting from cleared), expected nan_valid and nan_result.
    localparam logic [31:0] V_A [NV] = '{
        32'h3F80_0000, 32'h7F80_0001, 32'h7FC0_0002, 32'h3F80_0000, 32'h3F80_0000,
        32'h7FC0_0003, 32'h7F80_0000, 32'h3F80_0000, 32'h8000_0001};
    localparam logic [31:0] V_B [NV] = '{
        32'h4000_0000, 32'h3F80_0000, 32'h3F80_0000, 32'h0000_0001, 32'hFF80_0005,
        32'h7F80_0004, 32'h0000_0000, 32'h3F80_0000, 32'h7F80_0001};
    localparam logic [5:0] V_DP [NV] = '{
        6'h00, 6'h00, 6'h00, 6'h00, 6'h00, 6'h00, 6'h00, 6'h24, 6'h08};
    localparam logic [5:0] V_MSK [NV] = '{
        6'h3F, 6'h00, 6'h00, 6'h02, 6'h01, 6'h00, 6'h00, 6'h20, 6'h3F};
    localparam logic [5:0] V_STK [NV] = '{
        6'h00, 6'h01, 6'h00, 6'h02, 6'h01, 6'h01, 6'h00, 6'h24, 6'h0B};
    localparam logic V_NV [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
    localparam logic [31:0] V_NR [NV] = '{
        32'h0, 32'h7FC0_0001, 32'h7FC0_0002, 32'h0, 32'hFFC0_0005,
        32'h7FC0_0003, 32'h0, 32'h0, 32'h7FC0_0001};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [5:0]  dp_flags = '0;
    logic [5:0]  exc_mask = 6'h3F;
    logic        clear_flags = 1'b0;
    logic        insn_start = 1'b0;
    logic        irq_ack = 1'b0;
    logic [5:0]  sticky;
    logic        err_summary, busy, irq, nan_valid;
    logic [31:0] nan_result;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpx_status_ctrl dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
        .dp_flags(dp_flags), .exc_mask(exc_mask), .clear_flags(clear_flags),
        .insn_start(insn_start), .irq_ack(irq_ack), .sticky(sticky),
        .err_summary(err_summary), .busy(busy), .irq(irq),
        .nan_result(nan_result), .nan_valid(nan_valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse_clear();
        @(negedge clk) clear_flags = 1'b1;
        @(posedge clk);
        @(negedge clk) clear_flags = 1'b0;
    endtask

    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic [5:0] dp);
        @(negedge clk);
        op_a = a; op_b = b; dp_flags = dp; op_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0; dp_flags = '0;
    endtask

    task automatic pulse_start();
        @(negedge clk) insn_start = 1'b1;
        @(posedge clk);
        @(negedge clk) insn_start = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R12 reset state
        chk("R12 sticky", 32'(sticky), 32'h0);
        chk("R12 err_summary", 32'(err_summary), 32'h0);
        chk("R12 busy", 32'(busy), 32'h0);
        chk("R12 irq", 32'(irq), 32'h0);

        // Vector walk: R1 R2 R3 R4 R7 R8 R11
        for (int i = 0; i < NV; i++) begin
            pulse_clear();
            @(negedge clk);
            exc_mask = V_MSK[i];
            op_a = V_A[i]; op_b = V_B[i]; dp_flags = V_DP[i]; op_valid = 1'b1;
            #1;
            chk($sformatf("R11 nan_valid v%0d", i), 32'(nan_valid), 32'(V_NV[i]));
            if (V_NV[i]) chk($sformatf("R11 nan_result v%0d", i), nan_result, V_NR[i]);
            @(posedge clk);
            @(negedge clk);
            op_valid = 1'b0; dp_flags = '0;
            chk($sformatf("R1/R2/R3/R4 sticky v%0d", i), 32'(sticky), 32'(V_STK[i]));
            chk($sformatf("R7 err_summary v%0d", i), 32'(err_summary),
                32'(|(V_STK[i] & ~V_MSK[i])));
            chk($sformatf("R8 busy v%0d", i), 32'(busy), 32'(err_summary));
        end

        // R5 accumulation and ignored flags without op_valid
        pulse_clear();
        exc_mask = 6'h3F;
        run_op(32'h3F80_0000, 32'h3F80_0000, 6'h08);
        run_op(32'h3F80_0000, 32'h3F80_0000, 6'h10);
        chk("R5 accumulate", 32'(sticky), 32'h18);
        @(negedge clk);
        op_a = 32'h7F80_0001; dp_flags = 6'h23; op_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        dp_flags = '0; op_a = '0;
        chk("R5 ignored without op_valid", 32'(sticky), 32'h18);

        // R6 clear wins over same-cycle operation
        @(negedge clk);
        clear_flags = 1'b1; op_valid = 1'b1; dp_flags = 6'h3F;
        @(posedge clk);
        @(negedge clk);
        clear_flags = 1'b0; op_valid = 1'b0; dp_flags = '0;
        chk("R6 clear priority", 32'(sticky), 32'h0);

        // R7 mask change acts in the same cycle
        run_op(32'h3F80_0000, 32'h3F80_0000, 6'h04);
        exc_mask = 6'h00;
        #1 chk("R7 unmasked", 32'(err_summary), 32'h1);
        exc_mask = 6'h04;
        #1 chk("R7 masked", 32'(err_summary), 32'h0);
        chk("R8 busy masked", 32'(busy), 32'h0);

        // R9 boundary with nothing unmasked: no request
        pulse_start();
        chk("R9 masked boundary", 32'(irq), 32'h0);

        // R9 deferred request
        exc_mask = 6'h00;
        repeat (3) @(negedge clk);
        chk("R9 no boundary yet", 32'(irq), 32'h0);
        pulse_start();
        chk("R9 raised at boundary", 32'(irq), 32'h1);

        // R10 survives clear, drops on ack
        pulse_clear();
        chk("R10 held after clear", 32'(irq), 32'h1);
        chk("R10 es after clear", 32'(err_summary), 32'h0);
        @(negedge clk) irq_ack = 1'b1;
        @(posedge clk);
        @(negedge clk) irq_ack = 1'b0;
        chk("R10 ack drops", 32'(irq), 32'h0);

        // R10 ack beats same-cycle boundary
        run_op(32'h3F80_0000, 32'h3F80_0000, 6'h08);
        @(negedge clk) begin insn_start = 1'b1; irq_ack = 1'b1; end
        @(posedge clk);
        @(negedge clk) begin insn_start = 1'b0; irq_ack = 1'b0; end
        chk("R10 ack priority", 32'(irq), 32'h0);

        // R9 boundary with flags cleared: no request
        pulse_clear();
        pulse_start();
        chk("R9 clean boundary", 32'(irq), 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule